// File: doc/BRIEF.md
# Raster Timing and Colour-Bar Generator

This block generates the raster timing for a display panel, advancing one pixel per clock. Every setting sits in a small word-addressed register bank: the active picture size, the horizontal and vertical porch and pulse timing, and the sync polarity. From these settings it drives horizontal, vertical and composite sync, a data-enable strobe and the current pixel column and row.

A three-bit mode selects the output. The block can be off, it can forward pixels from an upstream valid/data source, or it can draw eight programmable vertical colour bars. Two frame events are latched into a sticky status register. Software acknowledges a status bit by writing a one to it, and a mask register gates the status bits onto a single interrupt line.

Software is expected to set the mode to zero before it changes the timing, and then select a running mode again. Each run therefore starts from column 0, row 0.

Top module: `rgen_top`

## Requirements
- R1: After reset the mode is 0, status is 0, the mask reads 6'h3F at word 6, all syncs sit at their inactive level with polarity 0, data-enable is low, RGB is zero and the interrupt is low.
- R2: Mode is word 0, bits 2:0. Value 1 is pass-through and value 4 is colour bars. Every other value disables the output: data-enable is low, RGB is zero, each sync stays at its inactive level, and the pixel column and row return to 0 one clock after the disable takes effect.
- R3: Word 2 holds the horizontal timing: front porch in bits 10:0, pulse width in bits 21:11 and back porch in bits 31:22. A line is laid out as the active pixels, then the front porch, then the sync pulse, then the back porch. The column runs from 0 to total−1 and then wraps.
- R4: Word 3 uses the same field layout for vertical timing, counted in lines. The row advances when the column wraps and itself wraps after the last back-porch line.
- R5: Word 1 holds the active width in bits 15:0 and the active height in bits 31:16. Only the low CW bits of each field are used.
- R6: Data-enable is high only for columns below the width on rows below the height. Outside that region RGB is zero.
- R7: Word 4 holds the polarity. Bit 0 inverts HSYNC, bit 1 inverts VSYNC and bit 2 inverts composite sync. With polarity 0 each sync is high while it is active. Composite sync is active while either sync is active.
- R8: In pass-through mode, while data-enable is high, RGB equals the source data when the source is valid and zero when it is not.
- R9: Words 8 to 15 hold bars 1 to 8, each with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The bar width is width/8. Column x shows bar min(x/(width/8), 7)+1, so any remainder columns take bar 8. A width below 8 shows bar 8 across the whole line.
- R10: Status is word 5. Bit 0 sets on the clock after the cycle at column 0, row height+vfront. Bit 1 sets on the clock after the cycle at column width−1, row height−1. Events count only while running. A set bit holds until it is acknowledged, and bits 5:2 read zero.
- R11: Writing word 5 clears each status bit written as 1. An event in the same cycle wins over the clear.
- R12: Word 6 is the mask, where a 1 masks a bit. The interrupt is high exactly when some unmasked status bit is set.
- R13: Entering a running mode from a disabled mode starts the scan at column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| src_valid | input | 1 | Upstream pixel valid |
| src_data | input | 24 | Upstream pixel, R in 23:16, G in 15:8, B in 7:0 |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| csync | output | 1 | Composite sync after polarity |
| de | output | 1 | Data enable |
| rgb | output | 24 | Pixel output |
| pix_x | output | CW+2 | Current column |
| pix_y | output | CW+2 | Current row |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters, CW=12 and AW=4. It then programs tiny rasters, 16×4 and 20×3 with porches of a few pixels, plus a 6×2 case. Because these frames are short, every cycle of several complete frames can be compared against an arithmetic model. That brings within reach the wrap of every counter, both interrupt events, bar remainders, a bar width of zero, all eight mode codes and an acknowledge that lands in the same cycle as a new event.

// File: rtl/rgen_pkg.sv
package rgen_pkg;
   localparam int RGB_W = 24;
   localparam int NBAR  = 8;
   localparam int NIRQ  = 6;

   localparam logic [2:0] MODE_PASS = 3'd1;
   localparam logic [2:0] MODE_BARS = 3'd4;

   // register word addresses
   localparam int A_MODE = 0;
   localparam int A_SIZE = 1;
   localparam int A_HTIM = 2;
   localparam int A_VTIM = 3;
   localparam int A_POL  = 4;
   localparam int A_IST  = 5;
   localparam int A_IMSK = 6;
   localparam int A_BAR  = 8;

   localparam int IRQ_VS   = 0;
   localparam int IRQ_LAST = 1;

   typedef struct packed {
      logic [9:0]  bp;
      logic [10:0] pw;
      logic [10:0] fp;
   } span_t;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb_t;
endpackage

// File: rtl/rgen_regs.sv
module rgen_regs
   import rgen_pkg::*;
#(
   parameter int CW = 12,
   parameter int AW = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [AW-1:0]          addr,
   input  logic [31:0]            wdata,
   input  logic                   ev_vs,
   input  logic                   ev_last,
   output logic [2:0]             mode,
   output logic [CW-1:0]          act_w,
   output logic [CW-1:0]          act_h,
   output span_t                  htim,
   output span_t                  vtim,
   output logic [2:0]             pol,
   output rgb_t [NBAR-1:0]        bars,
   output logic [NIRQ-1:0]        status,
   output logic [NIRQ-1:0]        mask,
   output logic [31:0]            rdata
);
   logic [31:0]     size_q;
   logic [NIRQ-1:0] ack;
   logic [NIRQ-1:0] ev;

   assign act_w = size_q[CW-1:0];
   assign act_h = size_q[16 +: CW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= '0;
         size_q <= '0;
         htim   <= '0;
         vtim   <= '0;
         pol    <= '0;
         mask   <= '1;
      end else if (wr) begin
         case (addr)
            AW'(A_MODE): mode   <= wdata[2:0];
            AW'(A_SIZE): size_q <= wdata;
            AW'(A_HTIM): htim   <= wdata;
            AW'(A_VTIM): vtim   <= wdata;
            AW'(A_POL):  pol    <= wdata[2:0];
            AW'(A_IMSK): mask   <= wdata[NIRQ-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bars <= '0;
      end else begin
         for (int k = 0; k < NBAR; k++) begin
            if (wr && addr == AW'(A_BAR + k)) bars[k] <= wdata[RGB_W-1:0];
         end
      end
   end

   // sticky status, write-one-to-clear, new events win
   assign ack = (wr && addr == AW'(A_IST)) ? wdata[NIRQ-1:0] : '0;
   assign ev  = {{(NIRQ-2){1'b0}}, ev_last, ev_vs};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~ack) | ev;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(A_MODE): rdata = {29'd0, mode};
         AW'(A_SIZE): rdata = size_q;
         AW'(A_HTIM): rdata = htim;
         AW'(A_VTIM): rdata = vtim;
         AW'(A_POL):  rdata = {29'd0, pol};
         AW'(A_IST):  rdata = {{(32-NIRQ){1'b0}}, status};
         AW'(A_IMSK): rdata = {{(32-NIRQ){1'b0}}, mask};
         default: ;
      endcase
      for (int k = 0; k < NBAR; k++) begin
         if (addr == AW'(A_BAR + k)) rdata = {{(32-RGB_W){1'b0}}, bars[k]};
      end
   end

   p_vs_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vs |=> status[IRQ_VS]);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status[IRQ_LAST] && !ack[IRQ_LAST]) |=> status[IRQ_LAST]);

   p_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AW'(A_IST) && wdata[IRQ_VS] && !ev_vs) |=> !status[IRQ_VS]);
endmodule

// File: rtl/rgen_scan.sv
module rgen_scan
   import rgen_pkg::*;
#(
   parameter int CW = 12,
   parameter int TW = CW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] act_w,
   input  logic [CW-1:0] act_h,
   input  span_t         htim,
   input  span_t         vtim,
   output logic [TW-1:0] hcnt,
   output logic [TW-1:0] vcnt,
   output logic [2:0]    bar_idx,
   output logic          de_raw,
   output logic          hs_act,
   output logic          vs_act,
   output logic          ev_vs_raw,
   output logic          ev_last_raw
);
   logic [TW-1:0] w_e, h_fs, h_fe, h_tot;
   logic [TW-1:0] v_e, v_fs, v_fe, v_tot;
   logic          h_last, v_last;
   logic [CW-4:0] bw;
   logic [CW-1:0] bw_m1, bpos;
   logic [2:0]    bidx;

   assign w_e   = TW'(act_w);
   assign h_fs  = w_e  + TW'(htim.fp);
   assign h_fe  = h_fs + TW'(htim.pw);
   assign h_tot = h_fe + TW'(htim.bp);
   assign v_e   = TW'(act_h);
   assign v_fs  = v_e  + TW'(vtim.fp);
   assign v_fe  = v_fs + TW'(vtim.pw);
   assign v_tot = v_fe + TW'(vtim.bp);

   assign h_last = ({1'b0, hcnt} + (TW+1)'(1)) >= {1'b0, h_tot};
   assign v_last = ({1'b0, vcnt} + (TW+1)'(1)) >= {1'b0, v_tot};

   assign bw    = act_w[CW-1:3];
   assign bw_m1 = {3'b000, bw} - CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
         bpos <= '0;
         bidx <= '0;
      end else if (!run) begin
         hcnt <= '0;
         vcnt <= '0;
         bpos <= '0;
         bidx <= '0;
      end else if (h_last) begin
         hcnt <= '0;
         bpos <= '0;
         bidx <= '0;
         vcnt <= v_last ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
         if (bidx != 3'd7 && bpos == bw_m1) begin
            bidx <= bidx + 1'b1;
            bpos <= '0;
         end else begin
            bpos <= bpos + 1'b1;
         end
      end
   end

   assign bar_idx     = (bw == '0) ? 3'd7 : bidx;
   assign de_raw      = (hcnt < w_e) && (vcnt < v_e);
   assign hs_act      = (hcnt >= h_fs) && (hcnt < h_fe);
   assign vs_act      = (vcnt >= v_fs) && (vcnt < v_fe);
   assign ev_vs_raw   = (hcnt == '0) && (vcnt == v_fs);
   assign ev_last_raw = (w_e != '0) && (v_e != '0) &&
                        (hcnt == w_e - 1'b1) && (vcnt == v_e - 1'b1);

   p_hwrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && h_last) |=> (hcnt == '0));

   p_vstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && h_last && !v_last) |=> (vcnt == $past(vcnt) + 1'b1));
endmodule

// File: rtl/rgen_pixel.sv
module rgen_pixel
   import rgen_pkg::*;
(
   input  logic             [2:0] mode,
   input  logic                   de,
   input  logic             [2:0] bar_idx,
   input  rgb_t  [NBAR-1:0]       bars,
   input  logic                   src_valid,
   input  logic [RGB_W-1:0]       src_data,
   output logic [RGB_W-1:0]       rgb
);
   always_comb begin
      rgb = '0;
      if (de) begin
         case (mode)
            MODE_PASS: if (src_valid) rgb = src_data;
            MODE_BARS: rgb = bars[bar_idx];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rgen_top.sv
module rgen_top
   import rgen_pkg::*;
#(
   parameter  int CW = 12,
   parameter  int AW = 4,
   localparam int TW = CW + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [AW-1:0]    reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             src_valid,
   input  logic [RGB_W-1:0] src_data,
   output logic             hsync,
   output logic             vsync,
   output logic             csync,
   output logic             de,
   output logic [RGB_W-1:0] rgb,
   output logic [TW-1:0]    pix_x,
   output logic [TW-1:0]    pix_y,
   output logic             irq
);
   if (CW < 11 || CW > 16) begin : g_bad_cw
      $error("rgen_top: CW must lie in 11..16");
   end
   if (AW < 4) begin : g_bad_aw
      $error("rgen_top: AW must be at least 4 to reach the bar words");
   end

   logic [2:0]        mode, pol, bar_idx;
   logic [CW-1:0]     act_w, act_h;
   span_t             htim, vtim;
   rgb_t [NBAR-1:0]   bars;
   logic [NIRQ-1:0]   status, mask;
   logic              run, de_raw, hs_act, vs_act, ev_vs_raw, ev_last_raw;
   logic [TW-1:0]     hcnt, vcnt;

   assign run = (mode == MODE_PASS) || (mode == MODE_BARS);

   rgen_regs #(.CW(CW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .ev_vs(run && ev_vs_raw), .ev_last(run && ev_last_raw),
      .mode(mode), .act_w(act_w), .act_h(act_h), .htim(htim), .vtim(vtim),
      .pol(pol), .bars(bars), .status(status), .mask(mask), .rdata(reg_rdata)
   );

   rgen_scan #(.CW(CW), .TW(TW)) u_scan (
      .clk(clk), .rst_n(rst_n), .run(run), .act_w(act_w), .act_h(act_h),
      .htim(htim), .vtim(vtim), .hcnt(hcnt), .vcnt(vcnt), .bar_idx(bar_idx),
      .de_raw(de_raw), .hs_act(hs_act), .vs_act(vs_act),
      .ev_vs_raw(ev_vs_raw), .ev_last_raw(ev_last_raw)
   );

   assign de    = run && de_raw;
   assign hsync = (run && hs_act) ^ pol[0];
   assign vsync = (run && vs_act) ^ pol[1];
   assign csync = (run && (hs_act || vs_act)) ^ pol[2];
   assign pix_x = hcnt;
   assign pix_y = vcnt;
   assign irq   = |(status & ~mask);

   rgen_pixel u_pixel (
      .mode(mode), .de(de), .bar_idx(bar_idx), .bars(bars),
      .src_valid(src_valid), .src_data(src_data), .rgb(rgb)
   );

   p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (rgb == '0));

   p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pix_x == '0 && pix_y == '0));

   p_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |-> !irq);
endmodule

// File: tb/rgen_top_tb.sv
module rgen_top_tb;
   import rgen_pkg::*;
   localparam int CW = 12;
   localparam int AW = 4;
   localparam int TW = CW + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = AW'(5);
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          src_valid = 1'b0;
   logic [23:0]   src_data = '0;
   logic          hsync, vsync, csync, de, irq;
   logic [23:0]   rgb;
   logic [TW-1:0] pix_x, pix_y;

   rgen_top #(.CW(CW), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
      .src_data(src_data), .hsync(hsync), .vsync(vsync), .csync(csync),
      .de(de), .rgb(rgb), .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   bit ack_all = 0;
   // model of programmed state
   int m_mode = 0, mw = 0, mh = 0, hfp = 0, hpw = 0, hbp = 0;
   int vfp = 0, vpw = 0, vbp = 0, mpol = 0, mmask = 63, mst = 0;
   int h = 0, v = 0, cyc = 0;
   int mbar [8];

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit runm();
      return (m_mode == 1) || (m_mode == 4);
   endfunction

   task automatic check_now();
      bit r;
      int dex, hs, vs, ex_rgb, bw, idx;
      r   = runm();
      dex = (r && h < mw && v < mh) ? 1 : 0;
      hs  = (r && h >= mw + hfp && h < mw + hfp + hpw) ? 1 : 0;
      vs  = (r && v >= mh + vfp && v < mh + vfp + vpw) ? 1 : 0;
      ex_rgb = 0;
      if (dex == 1) begin
         if (m_mode == 1) ex_rgb = src_valid ? int'(src_data) : 0;
         else begin
            bw  = mw / 8;
            idx = (bw == 0) ? 7 : h / bw;
            if (idx > 7) idx = 7;
            ex_rgb = mbar[idx];
         end
      end
      chk(r ? "R3" : "R2", "pix_x", pix_x, h);
      chk(r ? "R4" : "R13", "pix_y", pix_y, v);
      chk("R6", "de", de, dex);
      chk("R7", "hsync", hsync, hs ^ (mpol & 1));
      chk("R7", "vsync", vsync, vs ^ ((mpol >> 1) & 1));
      chk("R7", "csync", csync, (hs | vs) ^ ((mpol >> 2) & 1));
      chk(m_mode == 4 ? "R9" : "R8", "rgb", rgb, ex_rgb);
      chk("R12", "irq", irq, ((mst & ~mmask) & 63) != 0);
      if (!reg_wr && reg_addr == AW'(5)) chk("R10", "status", reg_rdata, mst);
   endtask

   task automatic shadow_write(int a, int d);
      case (a)
         0: m_mode = d & 7;
         1: begin mw = d & ((1 << CW) - 1); mh = (d >> 16) & ((1 << CW) - 1); end
         2: begin hfp = d & 2047; hpw = (d >> 11) & 2047; hbp = (d >> 22) & 1023; end
         3: begin vfp = d & 2047; vpw = (d >> 11) & 2047; vbp = (d >> 22) & 1023; end
         4: mpol = d & 7;
         6: mmask = d & 63;
         default: if (a >= 8 && a < 16) mbar[a-8] = d & 24'hffffff;
      endcase
   endtask

   task automatic step();
      bit r;
      int ev, clr, htot, vtot;
      r = runm();
      ev = 0;
      if (r && h == 0 && v == mh + vfp) ev |= 1;
      if (r && mw != 0 && mh != 0 && h == mw - 1 && v == mh - 1) ev |= 2;
      htot = mw + hfp + hpw + hbp;
      vtot = mh + vfp + vpw + vbp;
      clr = (reg_wr && reg_addr == AW'(5)) ? int'(reg_wdata[5:0]) : 0;
      @(posedge clk);
      if (r) begin
         if (h + 1 >= htot) begin
            h = 0;
            if (v + 1 >= vtot) v = 0; else v++;
         end else h++;
      end else begin
         h = 0;
         v = 0;
      end
      mst = (mst & ~clr) | ev;   // R11: set wins over clear
      if (reg_wr) shadow_write(int'(reg_addr), int'(reg_wdata));
      @(negedge clk);
   endtask

   task automatic wr_reg(int a, int d);
      reg_wr = 1'b1;
      reg_addr = AW'(a);
      reg_wdata = d;
      #1;
      check_now();
      step();
      reg_wr = 1'b0;
      reg_addr = AW'(5);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         cyc++;
         src_data  = 24'(cyc * 32'h00030507 ^ 32'h005a5a5a);
         src_valid = (cyc % 7) != 3;
         #1;
         check_now();
         if (ack_all) begin
            reg_wr = 1'b1;
            reg_addr = AW'(5);
            reg_wdata = 32'h3;
         end
         step();
         reg_wr = 1'b0;
      end
   endtask

   task automatic timing(int w, int hh, int f, int p, int b, int vf, int vp, int vb);
      wr_reg(1, (hh << 16) | w);
      wr_reg(2, (b << 22) | (p << 11) | f);
      wr_reg(3, (vb << 22) | (vp << 11) | vf);
   endtask

   initial begin
      for (int k = 0; k < 8; k++) mbar[k] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state while reset is held
      reg_addr = AW'(6);
      #1;
      chk("R1", "mask", reg_rdata, 63);
      chk("R1", "de", de, 0);
      chk("R1", "rgb", rgb, 0);
      chk("R1", "syncs", {hsync, vsync, csync}, 0);
      chk("R1", "irq", irq, 0);
      reg_addr = AW'(0);
      #1;
      chk("R1", "mode", reg_rdata, 0);
      reg_addr = AW'(5);
      #1;
      chk("R1", "status", reg_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run(3);

      // R5, R3, R4: 16x4 raster, bars (R9), events (R10), irq unmasked (R12)
      timing(16, 4, 2, 3, 1, 1, 2, 1);
      for (int k = 0; k < 8; k++) wr_reg(8 + k, ((k + 1) * 32'h00131517) & 32'hffffff);
      wr_reg(6, 0);
      wr_reg(0, 4);               // R13: start from 0,0
      run(2 * 22 * 8 + 5);
      wr_reg(0, 0);
      run(2);
      // R11: acknowledge bits one at a time
      wr_reg(5, 1);
      run(1);
      wr_reg(5, 2);
      reg_addr = AW'(5);
      #1;
      chk("R11", "status after acks", reg_rdata, 0);

      // R8 pass-through, R7 inverted polarity, R11 ack colliding with events
      wr_reg(4, 7);
      timing(20, 3, 2, 3, 1, 1, 2, 1);
      wr_reg(6, 2);
      wr_reg(0, 1);
      ack_all = 1;
      run(2 * 26 * 7);
      ack_all = 0;
      wr_reg(0, 0);
      run(2);

      // R9 remainder columns take bar 8
      wr_reg(4, 2);
      wr_reg(0, 4);
      run(26 * 7 + 4);
      // R2 direct switch to a disabled code, R13 restart
      wr_reg(0, 3);
      run(4);
      wr_reg(0, 4);
      run(40);
      wr_reg(0, 0);
      run(2);

      // R9 width below 8: whole line is bar 8
      wr_reg(4, 0);
      timing(6, 2, 2, 2, 2, 1, 2, 1);
      wr_reg(0, 4);
      run(2 * 12 * 6);

      // R2: every other mode code disables output
      for (int m = 2; m < 8; m++) begin
         if (m != 4) begin
            wr_reg(0, m);
            run(6);
         end
      end
      wr_reg(6, 63);
      run(4);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R13 watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule